// File: doc/BRIEF.md
# Folded Circular Convolution Unit

This block takes two sequences of N unsigned samples each and returns their N-point circular (cyclic) convolution. It works in two steps. First it forms the 2N-1 terms of the linear convolution: each term collects every element product whose two indices add up to that term's index. Then it folds the terms above the middle index back onto the terms below it. The middle term, index N-1, passes through without change.

Each output element is wide enough that neither the column sums nor the fold addition can overflow. The result is held in one output register. Both edges of the block use a valid/ready handshake:

- An input pair is accepted on a rising edge where `in_valid` and `in_ready` are both high.
- The result appears on the next cycle with `out_valid` high.
- `in_ready` is high whenever the output register is empty or its contents are being taken in the same cycle (`out_ready` high). A stalled output therefore blocks new input rather than losing a result.

Sample k of an input vector sits at bits `[k*W +: W]`. Output element n sits at bits `[n*OW +: OW]`, where OW = 2W + clog2(N) + 1.

Top module: `circ_conv_fold`

## Requirements
- R1: For every accepted input pair, output element n equals the sum over k of x(k)*h((n-k) mod N), where a negative index n-k wraps to N+n-k.
- R2: Output element N-1 equals the middle linear term, the sum of x(i)*h(N-1-i) over i = 0..N-1, with nothing folded onto it.
- R3: For n = 0..N-2, output element n equals linear term P(n) plus linear term P(n+N), where P(k) is the sum of x(i)*h(j) over all pairs with i+j = k.
- R4: Each output element is 2W+clog2(N)+1 bits wide and holds N*(2^W-1)^2 exactly when every sample is at its maximum.
- R5: `out_valid` is high in the cycle after an input is accepted, so latency is exactly one cycle.
- R6: A synchronous active-high `rst` clears `out_valid` and every bit of `y_out` to zero.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and both `out_valid` and `y_out` hold their values.
- R8: When x is a unit impulse (x(0)=1, all other samples 0), the outputs equal h, each sample zero-extended.
- R9: When no input is accepted, `y_out` keeps its value whatever `x_in` and `h_in` carry, and `out_valid` falls once `out_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can accept an input pair this cycle |
| x_in | input | N*W | First sequence, sample k at bits [k*W +: W] |
| h_in | input | N*W | Second sequence, sample k at bits [k*W +: W] |
| out_valid | output | 1 | Result register holds a valid result |
| out_ready | input | 1 | Downstream takes the result this cycle |
| y_out | output | N*OW | Circular convolution, element n at bits [n*OW +: OW] |

## Verification
The bench builds two copies of the unit. The first uses the defaults, N=4 and W=8: eight-bit arithmetic carries through all seven column sums and the fold, and the all-maximum pattern tests the headroom bits of the widened outputs. The second uses N=5 and W=1, which selects the AND-gate product variant and an odd sequence length. At that size every one of the 1024 input pairs can be applied, so the wrap-around indexing is covered exhaustively for a length other than four.

// File: rtl/circ_conv_pkg.sv
package circ_conv_pkg;

  // Width of a widened result element: product width plus headroom for
  // N column terms plus one bit for the fold addition.
  function automatic int result_width(input int w, input int n);
    return 2 * w + $clog2(n) + 1;
  endfunction

  // Number of linear-convolution terms for length n.
  function automatic int linear_terms(input int n);
    return 2 * n - 1;
  endfunction

endpackage

// File: rtl/cconv_products.sv
module cconv_products #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N*W-1:0]     x_vec,
  input  logic [N*W-1:0]     h_vec,
  output logic [N*N*2*W-1:0] prod
);
  localparam int PW = 2 * W;

  // prod entry (i*N + j) holds x(i) * h(j)
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (W == 1) begin : g_and
        assign prod[(i*N+j)*PW +: PW] = {1'b0, x_vec[i] & h_vec[j]};
      end else begin : g_mul
        assign prod[(i*N+j)*PW +: PW] =
          PW'(x_vec[i*W +: W]) * PW'(h_vec[j*W +: W]);
      end
    end
  end

endmodule

// File: rtl/cconv_columns.sv
module cconv_columns #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int OW = 19
) (
  input  logic [N*N*2*W-1:0]     prod,
  output logic [(2*N-1)*OW-1:0]  cols
);
  localparam int PW = 2 * W;
  localparam int NT = 2 * N - 1;

  // Column k gathers every product whose indices sum to k.
  for (genvar k = 0; k < NT; k++) begin : g_term
    logic [OW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < N; i++) begin
        if ((k - i) >= 0 && (k - i) < N) begin
          acc = acc + OW'(prod[(i*N + (k - i))*PW +: PW]);
        end
      end
    end
    assign cols[k*OW +: OW] = acc;
  end

endmodule

// File: rtl/cconv_fold.sv
module cconv_fold #(
  parameter int N  = 4,
  parameter int OW = 19
) (
  input  logic [(2*N-1)*OW-1:0] cols,
  output logic [N*OW-1:0]       y_vec
);

  for (genvar n = 0; n < N; n++) begin : g_out
    if (n == N - 1) begin : g_mid
      assign y_vec[n*OW +: OW] = cols[n*OW +: OW];
    end else begin : g_wrap
      assign y_vec[n*OW +: OW] = cols[n*OW +: OW] + cols[(n+N)*OW +: OW];
    end
  end

endmodule

// File: rtl/circ_conv_fold.sv
module circ_conv_fold #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N*W-1:0]       x_in,
  input  logic [N*W-1:0]       h_in,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [N*(2*W+$clog2(N)+1)-1:0] y_out
);
  localparam int OW = circ_conv_pkg::result_width(W, N);
  localparam int PW = 2 * W;
  localparam int NT = circ_conv_pkg::linear_terms(N);

  logic [N*N*PW-1:0] prod;
  logic [NT*OW-1:0]  cols;
  logic [N*OW-1:0]   y_comb;
  logic              accept;

  cconv_products #(.N(N), .W(W)) u_prod (
    .x_vec (x_in),
    .h_vec (h_in),
    .prod  (prod)
  );

  cconv_columns #(.N(N), .W(W), .OW(OW)) u_cols (
    .prod (prod),
    .cols (cols)
  );

  cconv_fold #(.N(N), .OW(OW)) u_fold (
    .cols  (cols),
    .y_vec (y_comb)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      y_out     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      y_out     <= y_comb;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/circ_conv_fold_chk.sv
module circ_conv_fold_chk #(
  parameter int N  = 4,
  parameter int W  = 8,
  parameter int OW = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [N*W-1:0]    x_in,
  input logic [N*W-1:0]    h_in,
  input logic              out_valid,
  input logic              out_ready,
  input logic [N*OW-1:0]   y_out
);

  assert_clear_R6: assert property (@(posedge clk)
    rst |=> (!out_valid && y_out == '0));

  assert_latency_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(y_out)));

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_ready) |=> $stable(y_out));

  assert_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_ready) |=> !out_valid);

endmodule

bind circ_conv_fold circ_conv_fold_chk #(.N(N), .W(W), .OW(OW)) u_chk (.*);

// File: tb/circ_conv_fold_test.sv
module circ_conv_fold_test;
  localparam int N   = 4;
  localparam int W   = 8;
  localparam int OW  = 2*W + $clog2(N) + 1;
  localparam int N2  = 5;
  localparam int W2  = 1;
  localparam int OW2 = 2*W2 + $clog2(N2) + 1;
  localparam int ROWS = 8;

  // stimulus table: x vectors, h vectors (sample 0 in the low byte)
  localparam logic [N*W-1:0] TX [ROWS] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0403_0201,
    32'h8000_0000, 32'h00FF_00FF, 32'h1234_5678, 32'hA5A5_5A5A};
  localparam logic [N*W-1:0] TH [ROWS] = '{
    32'h0000_0000, 32'hFFFF_FFFF, 32'h4433_2211, 32'h0807_0605,
    32'h0000_0001, 32'hFF00_FF00, 32'h9ABC_DEF0, 32'h0F0F_F0F0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              in_valid = 1'b0, out_ready = 1'b1;
  logic              in_ready, out_valid;
  logic [N*W-1:0]    x_in = '0, h_in = '0;
  logic [N*OW-1:0]   y_out;

  logic              in_valid2 = 1'b0;
  logic              in_ready2, out_valid2;
  logic [N2*W2-1:0]  x2 = '0, h2 = '0;
  logic [N2*OW2-1:0] y2;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  circ_conv_fold #(.N(N), .W(W)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .x_in(x_in), .h_in(h_in), .out_valid(out_valid),
    .out_ready(out_ready), .y_out(y_out));

  circ_conv_fold #(.N(N2), .W(W2)) uut_small (
    .clk(clk), .rst(rst), .in_valid(in_valid2), .in_ready(in_ready2),
    .x_in(x2), .h_in(h2), .out_valid(out_valid2),
    .out_ready(1'b1), .y_out(y2));

  function automatic longint ref_y(input int n, input int w,
                                   input logic [63:0] xv, input logic [63:0] hv,
                                   input int idx);
    longint s = 0;
    logic [63:0] mask = (64'd1 << w) - 64'd1;
    for (int k = 0; k < n; k++) begin
      int m = idx - k;
      if (m < 0) m = m + n;
      s += longint'((xv >> (k*w)) & mask) * longint'((hv >> (m*w)) & mask);
    end
    return s;
  endfunction

  function automatic logic [N*OW-1:0] exp_a(input logic [N*W-1:0] xv,
                                            input logic [N*W-1:0] hv);
    logic [N*OW-1:0] e;
    for (int n = 0; n < N; n++) e[n*OW +: OW] = OW'(ref_y(N, W, 64'(xv), 64'(hv), n));
    return e;
  endfunction

  function automatic logic [N2*OW2-1:0] exp_b(input logic [N2*W2-1:0] xv,
                                              input logic [N2*W2-1:0] hv);
    logic [N2*OW2-1:0] e;
    for (int n = 0; n < N2; n++) e[n*OW2 +: OW2] = OW2'(ref_y(N2, W2, 64'(xv), 64'(hv), n));
    return e;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic send(input logic [N*W-1:0] xv, input logic [N*W-1:0] hv);
    x_in = xv; h_in = hv; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send2(input logic [N2*W2-1:0] xv, input logic [N2*W2-1:0] hv);
    x2 = xv; h2 = hv; in_valid2 = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid2 = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N*W-1:0] xr, hr;
    logic [N*OW-1:0] held;
    longint p0, p4;
    repeat (2) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R6: reset state
    chk("R6 out_valid after reset", 128'(out_valid), 128'(0));
    chk("R6 y_out after reset", 128'(y_out), 128'(0));
    chk("R7 in_ready when empty", 128'(in_ready), 128'(1));

    // table walk: R1 on every row, R5 latency
    for (int r = 0; r < ROWS; r++) begin
      send(TX[r], TH[r]);
      chk("R5 out_valid one cycle after accept", 128'(out_valid), 128'(1));
      chk("R1 circular result", 128'(y_out), 128'(exp_a(TX[r], TH[r])));
      if (r == 1) begin
        chk("R4 all-max element 0", 128'(y_out[0 +: OW]), 128'(4 * 255 * 255));
        chk("R4 all-max element N-1", 128'(y_out[(N-1)*OW +: OW]), 128'(4 * 255 * 255));
      end
      if (r == 2) begin
        logic [N*OW-1:0] imp;
        for (int n = 0; n < N; n++) imp[n*OW +: OW] = OW'(TH[r][n*W +: W]);
        chk("R8 unit impulse gives h", 128'(y_out), 128'(imp));
      end
      if (r == 3) begin
        // ramp x=1,2,3,4  h=5,6,7,8
        chk("R2 middle term", 128'(y_out[3*OW +: OW]), 128'(1*8 + 2*7 + 3*6 + 4*5));
        p0 = 1*5;
        p4 = 2*8 + 3*7 + 4*6;
        chk("R3 fold P0+P4", 128'(y_out[0 +: OW]), 128'(p0 + p4));
        chk("R3 fold P1+P5", 128'(y_out[OW +: OW]), 128'((1*6 + 2*5) + (3*8 + 4*7)));
      end
    end

    // R9: no accept, inputs change, y_out holds and out_valid falls
    held = y_out;
    x_in = 32'hDEAD_BEEF; h_in = 32'h0102_0304;
    @(posedge clk); @(negedge clk);
    chk("R9 out_valid drops when idle", 128'(out_valid), 128'(0));
    chk("R9 y_out holds when idle", 128'(y_out), 128'(held));

    // R7: back-pressure
    out_ready = 1'b0;
    send(32'h0102_0304, 32'h0506_0708);
    held = y_out;
    chk("R7 in_ready low while stalled", 128'(in_ready), 128'(0));
    x_in = 32'h1111_1111; h_in = 32'h2222_2222; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7 out_valid held under stall", 128'(out_valid), 128'(1));
    chk("R7 y_out held under stall", 128'(y_out), 128'(held));
    chk("R7 stalled result value", 128'(y_out), 128'(exp_a(32'h0102_0304, 32'h0506_0708)));
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk("R7 pending input taken on release", 128'(y_out), 128'(exp_a(32'h1111_1111, 32'h2222_2222)));

    // random vectors
    for (int r = 0; r < 150; r++) begin
      xr = $urandom(); hr = $urandom();
      send(xr, hr);
      chk("R1 random", 128'(y_out), 128'(exp_a(xr, hr)));
    end

    // R6: reset mid-run
    send(32'hFFFF_FFFF, 32'h0000_0101);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    chk("R6 out_valid after mid-run reset", 128'(out_valid), 128'(0));
    chk("R6 y_out after mid-run reset", 128'(y_out), 128'(0));

    // exhaustive 1-bit, length-5 instance
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        send2(5'(a), 5'(b));
        chk("R1 N5W1 exhaustive", 128'(y2), 128'(exp_b(5'(a), 5'(b))));
      end
    end
    send2(5'b00001, 5'b10110);
    chk("R8 N5W1 impulse", 128'(y2),
        128'({6'd1, 6'd0, 6'd1, 6'd1, 6'd0}));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule